// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame addressed to a group (multicast) destination is kept or discarded. When the receive path presents a 48-bit destination address with a one-cycle strobe, the block runs a CRC-32 over the address, one byte per clock. It takes the six most significant bits of the resulting register as an index into a 64-bit table. A set table bit keeps the frame and a clear bit drops it.

The host fills the table through a simple write port as four 16-bit registers. The upper two index bits select the register and the lower four select the bit inside it. Addresses whose group bit is clear are not looked up: the decision is reported as not applicable. A bypass keeps every group address whatever the table holds. It applies only when both the receive-all control and the open-multicast control are set.

The table and the controls are captured when a lookup starts. Each decision therefore reflects the state at its own strobe, and the host may rewrite the table at any time.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset all four table registers hold zero, `dec_valid` is 0, and a lookup of any group address with no bypass is dropped.
- R2: A write with `cfg_wr_en` = 1 replaces the whole 16-bit register numbered by `cfg_wr_sel`. Register k holds table bits 16k to 16k+15, with `cfg_wr_data[j]` becoming table bit 16k+j.
- R3: The index is bits 31:26 of a CRC-32 register. The register starts at 0xFFFFFFFF and has no final inversion. Each step shifts left and XORs polynomial 0x04C11DB7 when bit 31 XOR the input bit is 1. The input bits are `da_addr[0]`, `da_addr[1]`, ..., `da_addr[47]` in that order, so byte 0 is `da_addr[7:0]` and each byte is fed LSB first.
- R4: Index bits 5:4 pick the register and bits 3:0 pick the bit within it. A group address is accepted (`dec_accept` = 1) exactly when that bit is 1.
- R5: The group bit is `da_addr[0]`. When it is 0, the decision carries `dec_group` = 0 and `dec_accept` = 0, whatever the table and controls hold.
- R6: When `ctl_rx_all` and `ctl_grp_open` are both 1 at the accepting edge, a group address is accepted regardless of the table. Either control alone has no effect.
- R7: A strobe sampled with no lookup in progress starts a lookup. `dec_valid` is a single-cycle pulse that is high after the sixth rising edge following the accepting edge and low at all other times.
- R8: A strobe sampled while a lookup is in progress is ignored: it produces no decision and does not alter the pending one.
- R9: The table and both controls are captured at the accepting edge. A table write made after that edge affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr_en | input | 1 | Table register write enable |
| cfg_wr_sel | input | 2 | Table register number |
| cfg_wr_data | input | 16 | Table register write data |
| ctl_rx_all | input | 1 | Receive-all control; bypass needs this and ctl_grp_open |
| ctl_grp_open | input | 1 | Open-multicast control; bypass needs this and ctl_rx_all |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision valid pulse |
| dec_accept | output | 1 | Frame kept (group address accepted) |
| dec_group | output | 1 | Lookup applied (address is a group address) |

## Verification
The assertions assume that the reset is asserted before the first strobe and that the write select is always one of the four register numbers. They also assume that a strobe only counts when no lookup is running. The bench drives every input on the falling edge and issues table writes only between lookups, or at a known cycle inside one. A fresh strobe is issued only after the previous pulse, except where the bench overlaps a strobe on purpose to exercise the ignored case. Expected indices come from a bitwise CRC model in the bench, applied to a long pseudo-random address stream.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

  // One byte of a left-shifting CRC, data fed LSB first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_table_regs.sv
module mhf_table_regs #(
  parameter int REG_W  = 16,
  parameter int N_REGS = 4,
  localparam int SEL_W = $clog2(N_REGS),
  localparam int TBL_W = REG_W * N_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [TBL_W-1:0] table_flat
);
  logic [REG_W-1:0] regs_q [N_REGS];

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[k] <= '0;
      else if (hit) regs_q[k] <= wr_data;
    end

    assign table_flat[k*REG_W +: REG_W] = regs_q[k];
  end

  assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int N_BYTES = 6,
  parameter int IDX_W   = 6,
  localparam int ADDR_W = N_BYTES * BYTE_W,
  localparam int CNT_W  = $clog2(N_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              last,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_BYTES - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              take, crc_en;
  logic [BYTE_W-1:0] bytes [N_BYTES];

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign bytes[b] = addr_q[b*BYTE_W +: BYTE_W];
  end

  assign take    = start && !busy_q;
  assign crc_nxt = crc_step_byte(crc_q, bytes[cnt_q]);
  assign last    = busy_q && (cnt_q == LAST_CNT);
  assign busy    = busy_q;
  assign idx     = crc_nxt[CRC_W-1 -: IDX_W];

  always_comb begin
    crc_en = take || busy_q;
    crc_d  = crc_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (take) begin
      crc_d  = CRC_INIT;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      crc_d  = crc_nxt;
      cnt_d  = cnt_q + 1'b1;
      busy_d = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (take) addr_q <= addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (crc_en) begin
      crc_q  <= crc_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= LAST_CNT);
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy_q && cnt_q == '0);
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int REG_W      = 16,
  parameter int N_REGS     = 4,
  localparam int ADDR_W = ADDR_BYTES * 8,
  localparam int TBL_W  = REG_W * N_REGS,
  localparam int IDX_W  = $clog2(TBL_W),
  localparam int SEL_W  = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic              ctl_rx_all,
  input  logic              ctl_grp_open,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da_addr,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_group
);
  logic [TBL_W-1:0] table_flat, snap_q;
  logic             busy, last, take;
  logic [IDX_W-1:0] idx;
  logic             grp_q, byp_q;
  logic             vld_q, acc_q, grp_out_q;
  logic             vld_d, acc_d, grp_out_d;

  mhf_table_regs #(.REG_W(REG_W), .N_REGS(N_REGS)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .table_flat(table_flat)
  );

  mhf_crc_engine #(.N_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .start(da_valid), .addr(da_addr),
    .busy(busy), .last(last), .idx(idx)
  );

  assign take = da_valid && !busy;

  // Snapshot of table and controls at the accepting edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      grp_q  <= 1'b0;
      byp_q  <= 1'b0;
    end else if (take) begin
      snap_q <= table_flat;
      grp_q  <= da_addr[0];
      byp_q  <= ctl_rx_all && ctl_grp_open;
    end
  end

  always_comb begin
    vld_d     = last;
    grp_out_d = last && grp_q;
    acc_d     = last && grp_q && (byp_q || snap_q[idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      acc_q     <= 1'b0;
      grp_out_q <= 1'b0;
    end else begin
      vld_q     <= vld_d;
      acc_q     <= acc_d;
      grp_out_q <= grp_out_d;
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;
  assign dec_group  = grp_out_q;

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !dec_valid);
  assert_nongroup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_group |-> !dec_accept);
  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_group && byp_q |-> dec_accept);
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && da_valid |=> $stable(snap_q) && $stable(grp_q) && $stable(byp_q));
endmodule

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [1:0]  cfg_wr_sel;
  logic [15:0] cfg_wr_data;
  logic        ctl_rx_all, ctl_grp_open;
  logic        da_valid;
  logic [47:0] da_addr;
  logic        dec_valid, dec_accept, dec_group;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] tbl_m;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .ctl_rx_all(ctl_rx_all), .ctl_grp_open(ctl_grp_open),
    .da_valid(da_valid), .da_addr(da_addr), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_group(dec_group)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int i = 0; i < 48; i++) begin
      fb = c[31] ^ a[i];
      c  = c << 1;
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic ref_acc(input logic [47:0] a, input logic [63:0] t,
                                   input logic byp);
    return a[0] && (byp || t[ref_idx(a)]);
  endfunction

  task automatic next_addr(output logic [47:0] a);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    a = rng[47:0];
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    tbl_m[sel*16 +: 16] = d;
  endtask

  task automatic lookup(input logic [47:0] a, input logic rxa, input logic gro,
                        input string req);
    logic early = 1'b0;
    logic exp_acc;
    exp_acc = ref_acc(a, tbl_m, rxa && gro);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; ctl_rx_all = rxa; ctl_grp_open = gro;
    @(negedge clk);
    da_valid = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (dec_valid) early = 1'b1;
    end
    @(negedge clk);
    chk(dec_valid && !early, "R7 timing", {early, dec_valid}, 2'b01);
    chk(dec_group == a[0], {req, " R5 group"}, dec_group, a[0]);
    chk(dec_accept == exp_acc, req, dec_accept, exp_acc);
    @(negedge clk);
    chk(!dec_valid, "R7 pulse", dec_valid, 0);
  endtask

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] a, b;
    logic late;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = '0; cfg_wr_data = '0;
    ctl_rx_all = 1'b0; ctl_grp_open = 1'b0; da_valid = 1'b0; da_addr = '0;
    tbl_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dec_valid && !dec_accept, "R1 reset outputs", {dec_valid, dec_accept}, 0);

    // R1: zero table drops group addresses
    for (int i = 0; i < 8; i++) begin
      next_addr(a); a[0] = 1'b1;
      lookup(a, 1'b0, 1'b0, "R1 zero table");
    end

    // R2/R4: full table accepts
    for (int s = 0; s < 4; s++) wr(2'(s), 16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      next_addr(a); a[0] = 1'b1;
      lookup(a, 1'b0, 1'b0, "R4 full table");
    end

    // R2/R3/R4: patterned tables, register rewritten in place
    wr(2'd0, 16'h1111); wr(2'd1, 16'h0F0F); wr(2'd2, 16'h1234); wr(2'd3, 16'hFFFE);
    wr(2'd1, 16'hA5C3);
    for (int i = 0; i < 200; i++) begin
      next_addr(a); a[0] = 1'b1;
      lookup(a, 1'b0, 1'b0, "R3 R4 R2 pattern");
    end
    wr(2'd0, 16'hEDCB); wr(2'd2, 16'h5A5A); wr(2'd3, 16'h0001);
    for (int i = 0; i < 100; i++) begin
      next_addr(a); a[0] = 1'b1;
      lookup(a, 1'b0, 1'b0, "R3 R4 R2 pattern2");
    end

    // R5: individual addresses never apply, even with bypass
    for (int s = 0; s < 4; s++) wr(2'(s), 16'hFFFF);
    for (int i = 0; i < 16; i++) begin
      next_addr(a); a[0] = 1'b0;
      lookup(a, i[0], i[0], "R5 individual");
    end

    // R6: bypass needs both controls
    for (int s = 0; s < 4; s++) wr(2'(s), 16'h0000);
    for (int i = 0; i < 12; i++) begin
      next_addr(a); a[0] = 1'b1;
      lookup(a, i[0], i[1], "R6 bypass");
    end

    // R8: overlapping strobe ignored
    next_addr(a); a[0] = 1'b1;
    next_addr(b); b[0] = 1'b1;
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; ctl_rx_all = 1'b1; ctl_grp_open = 1'b1;
    @(negedge clk);
    da_addr = b; ctl_rx_all = 1'b0; ctl_grp_open = 1'b0;
    @(negedge clk);
    da_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(dec_valid && dec_accept, "R8 first result kept", {dec_valid, dec_accept}, 2'b11);
    late = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (dec_valid) late = 1'b1;
    end
    chk(!late, "R8 no second decision", late, 0);

    // R9: write during lookup affects only the next lookup
    next_addr(a); a[0] = 1'b1;
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; ctl_rx_all = 1'b0; ctl_grp_open = 1'b0;
    @(negedge clk);
    da_valid = 1'b0;
    cfg_wr_en = 1'b1; cfg_wr_sel = ref_idx(a) >> 4; cfg_wr_data = 16'hFFFF;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    tbl_m[(ref_idx(a) >> 4)*16 +: 16] = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk(dec_valid && !dec_accept, "R9 old table used", {dec_valid, dec_accept}, 2'b10);
    @(negedge clk);
    lookup(a, 1'b0, 1'b0, "R9 new table used");
    chk(tbl_m[ref_idx(a)] == 1'b1, "R9 model", tbl_m[ref_idx(a)], 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule